// File: doc/BRIEF.md
# Smart-card PPS exchange tracker

This block watches the stream of characters that a passive smart-card line receiver captures. It follows the start of each card session and decides when the card and the reader agree to switch to a faster bit timing. A session opens when the card reset line rises. The tracker then parses the answer-to-reset (ATR) in real time, then the protocol-and-parameters-selection (PPS) request and then the PPS response. When the check byte of a valid response has been received, it writes new half, one and one-and-a-half elementary-time-unit (etu) counts, in card clocks, into the receiver's timing registers. No host software takes part, so the change lands exactly on the byte boundary where the next character starts under the new timing.

The receiver feeds one character per `chr_vld` strobe. The tracker returns the three etu counts, a one-cycle `etu_load` strobe whenever they are rewritten, and an `act_flag` that marks the character on which a negotiated timing was applied, so that the flag can travel with that character's report. Once the response check byte has passed, or once any check fails, the tracker sits in an inactive state until the reset line rises again.

States: `ST_OFF` (inactive), `ST_TS` (first ATR character), `ST_T0` (format character), `ST_IFB` (interface characters), `ST_HIST` (historical characters), `ST_TCK` (ATR check character), `ST_PPSS` (first character after the ATR), `ST_REQ0`, `ST_REQOPT`, `ST_REQPCK` (request format byte, optional bytes, check byte), `ST_RSPS`, `ST_RSP0`, `ST_RSPOPT`, `ST_RSPPCK` (the same for the response). Transitions: a reset rise moves any state to `ST_TS`. TS 8'h3B goes to `ST_T0`, anything else goes to `ST_OFF`. T0 and each TDi select `ST_IFB`, `ST_HIST`, `ST_TCK` or `ST_PPSS` according to what remains. 8'hFF leads to `ST_REQ0`, anything else leads to `ST_OFF`. The request walks through its optional bytes to `ST_REQPCK`, then to `ST_RSPS`. The response goes through `ST_RSP0` and `ST_RSPOPT` to `ST_RSPPCK`, and then always to `ST_OFF`. Any invalid response byte leads to `ST_OFF` at once.

Top module: `ppsx_tracker`

## Requirements
- R1: After system reset `etu_half`, `etu_one` and `etu_onehalf` read 186, 372 and 558, and `etu_load` and `act_flag` are 0.
- R2: On the clock edge that samples a low-to-high change of `card_rst`, the tracker restarts at the ATR's first character. It writes the default counts (186/372/558) and pulses `etu_load` for one cycle without `act_flag`. This holds also in the middle of a session.
- R3: If the first character of a session is not 8'h3B, no later character of that session causes an `etu_load`.
- R4: The ATR ends as follows. T0 bits 3..0 give the number of historical characters. Bits 4, 5, 6 and 7 of T0 and of each TDi mark that TAi, TBi, TCi and TDi follow, in that order. A TCK character ends the ATR when any TDi has a nonzero low nibble (a protocol other than T=0).
- R5: The character right after the ATR must be 8'hFF (PPSS) to start request parsing. Any other value makes the tracker inactive.
- R6: Bits 4, 5 and 6 of the request's PPS0 mark PPS1, PPS2 and PPS3, which follow in that order before the request check byte. PPS1 is the byte that is kept.
- R7: The response must start with 8'hFF. Its PPS0 bits 6..4 may set only bits that the request also set. Its PPS1, when present, must equal the request's PPS1. Any violation makes the tracker inactive. A response without PPS1 ends without a load.
- R8: On the response check byte, if the XOR of all response bytes including the check byte is 0, PPS1 was present and its codes are supported, the new counts are written. `etu_load` and `act_flag` are then both 1 for exactly the one cycle after that character's strobe. `etu_half` is half of `etu_one`, and `etu_onehalf` is `etu_one` plus `etu_half`.
- R9: PPS1 bits 7..4 (Fi) map to clocks: 0,1→372, 2→558, 3→744, 4→1116, 5→1488, 6→1860, 9→512, 10→768, 11→1024, 12→1536, 13→2048. PPS1 bits 3..0 (Di) codes 1..7 mean 1,2,4,…,64. `etu_one` becomes Fi/Di. An unlisted Fi, a Di code outside 1..7, or an odd or fractional Fi/Di leaves the counts unchanged with no load.
- R10: After the response check byte, whatever its outcome, further characters cause no load and leave the counts unchanged until the next reset rise.
- R11: Characters strobed while `card_rst` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| card_rst | input | 1 | Card reset line level, already in the clock domain |
| chr_vld | input | 1 | One-cycle strobe: a captured character is on `chr_data` |
| chr_data | input | 8 | Captured character |
| etu_half | output | ETU_W | Card clocks in half an etu |
| etu_one | output | ETU_W | Card clocks in one etu |
| etu_onehalf | output | ETU_W | Card clocks in one and a half etu |
| etu_load | output | 1 | One-cycle strobe: the three counts were just written |
| act_flag | output | 1 | Negotiated timing applied on the character just strobed |

## Verification
Every result is registered once. The load strobe, the flag and the new counts for a character strobed at clock edge k are visible between edges k and k+1. A reset rise sampled at edge k shows its default load in the same window. The bench drives each strobe on a falling edge and drops it on the next falling edge. At that moment it compares all outputs, which places each check in that single-cycle window. The check after every character of a session requires the strobe to be low everywhere except on the final check byte, so a load one character early or late is caught.

// File: rtl/ppsx_pkg.sv
package ppsx_pkg;

    localparam int FCLK_W = 12;

    typedef enum logic [3:0] {
        ST_OFF, ST_TS, ST_T0, ST_IFB, ST_HIST, ST_TCK, ST_PPSS,
        ST_REQ0, ST_REQOPT, ST_REQPCK, ST_RSPS, ST_RSP0, ST_RSPOPT, ST_RSPPCK
    } trk_state_e;

    // Clock-rate conversion factor per Fi code; 0 marks an unsupported code.
    function automatic logic [FCLK_W-1:0] fi_clocks(input logic [3:0] code);
        unique case (code)
            4'd0, 4'd1: fi_clocks = 12'd372;
            4'd2:       fi_clocks = 12'd558;
            4'd3:       fi_clocks = 12'd744;
            4'd4:       fi_clocks = 12'd1116;
            4'd5:       fi_clocks = 12'd1488;
            4'd6:       fi_clocks = 12'd1860;
            4'd9:       fi_clocks = 12'd512;
            4'd10:      fi_clocks = 12'd768;
            4'd11:      fi_clocks = 12'd1024;
            4'd12:      fi_clocks = 12'd1536;
            4'd13:      fi_clocks = 12'd2048;
            default:    fi_clocks = '0;
        endcase
    endfunction

    // Where ATR parsing goes once the current interface group is known.
    function automatic trk_state_e atr_next(input logic [3:0] ifb,
                                            input logic [3:0] hist,
                                            input logic       tck);
        if (ifb != 4'd0)       atr_next = ST_IFB;
        else if (hist != 4'd0) atr_next = ST_HIST;
        else if (tck)          atr_next = ST_TCK;
        else                   atr_next = ST_PPSS;
    endfunction

endpackage

// File: rtl/ppsx_rise_det.sv
module ppsx_rise_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic lvl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q;
endmodule

// File: rtl/ppsx_etu_lut.sv
module ppsx_etu_lut #(
    parameter int ETU_W = 12
) (
    input  logic [7:0]       pps1,
    output logic             ok,
    output logic [ETU_W-1:0] one
);
    import ppsx_pkg::*;

    logic [FCLK_W-1:0] fclk;
    logic [2:0]        sh;
    logic              di_ok;
    logic [FCLK_W-1:0] rem_mask;

    always_comb begin
        fclk     = fi_clocks(pps1[7:4]);
        di_ok    = (pps1[3:0] >= 4'd1) && (pps1[3:0] <= 4'd7);
        sh       = pps1[2:0] - 3'd1;
        rem_mask = (FCLK_W'(2) << sh) - FCLK_W'(1);
        ok       = (fclk != '0) && di_ok && ((fclk & rem_mask) == '0);
        one      = ETU_W'(fclk >> sh);
    end
endmodule

// File: rtl/ppsx_tracker.sv
module ppsx_tracker #(
    parameter int ETU_W   = 12,
    parameter int DEF_ETU = 372
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             card_rst,
    input  logic             chr_vld,
    input  logic [7:0]       chr_data,
    output logic [ETU_W-1:0] etu_half,
    output logic [ETU_W-1:0] etu_one,
    output logic [ETU_W-1:0] etu_onehalf,
    output logic             etu_load,
    output logic             act_flag
);
    import ppsx_pkg::*;

    localparam logic [ETU_W-1:0] DEF_ONE  = ETU_W'(DEF_ETU);
    localparam logic [ETU_W-1:0] DEF_HALF = DEF_ONE >> 1;
    localparam logic [ETU_W-1:0] DEF_OH   = DEF_ONE + DEF_HALF;

    trk_state_e st, nxt;
    logic [3:0] ifb_mask, n_ifb;
    logic [3:0] hist_left, n_hist;
    logic       need_tck, n_tck;
    logic [2:0] req_mask, n_req;
    logic [2:0] opt_mask, n_opt;
    logic [7:0] req_pps1, n_rp1;
    logic [7:0] rsp_xor, n_x;
    logic       rsp_has1, n_has1;
    logic       fire;
    logic       sess_rise;
    logic       lut_ok;
    logic [ETU_W-1:0] lut_one;

    ppsx_rise_det rise_i (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (card_rst),
        .rise (sess_rise)
    );

    ppsx_etu_lut #(.ETU_W(ETU_W)) lut_i (
        .pps1(req_pps1),
        .ok  (lut_ok),
        .one (lut_one)
    );

    // Next state and parse context.
    always_comb begin
        nxt    = st;
        n_ifb  = ifb_mask;
        n_hist = hist_left;
        n_tck  = need_tck;
        n_req  = req_mask;
        n_opt  = opt_mask;
        n_rp1  = req_pps1;
        n_x    = rsp_xor;
        n_has1 = rsp_has1;
        fire   = 1'b0;
        if (sess_rise) begin
            nxt    = ST_TS;
            n_tck  = 1'b0;
            n_has1 = 1'b0;
        end else if (chr_vld && card_rst) begin
            unique case (st)
                ST_OFF: nxt = ST_OFF;
                ST_TS:  nxt = (chr_data == 8'h3B) ? ST_T0 : ST_OFF;
                ST_T0: begin
                    n_ifb  = chr_data[7:4];
                    n_hist = chr_data[3:0];
                    nxt    = atr_next(chr_data[7:4], chr_data[3:0], need_tck);
                end
                ST_IFB: begin
                    if (ifb_mask[2:0] == 3'd0) begin
                        n_ifb = chr_data[7:4];
                        n_tck = need_tck | (chr_data[3:0] != 4'd0);
                    end else begin
                        n_ifb = ifb_mask & (ifb_mask - 4'd1);
                    end
                    nxt = atr_next(n_ifb, hist_left, n_tck);
                end
                ST_HIST: begin
                    n_hist = hist_left - 4'd1;
                    nxt    = atr_next(4'd0, n_hist, need_tck);
                end
                ST_TCK:  nxt = ST_PPSS;
                ST_PPSS: nxt = (chr_data == 8'hFF) ? ST_REQ0 : ST_OFF;
                ST_REQ0: begin
                    n_req = chr_data[6:4];
                    n_opt = chr_data[6:4];
                    nxt   = (chr_data[6:4] != 3'd0) ? ST_REQOPT : ST_REQPCK;
                end
                ST_REQOPT: begin
                    if (opt_mask[0]) n_rp1 = chr_data;
                    n_opt = opt_mask & (opt_mask - 3'd1);
                    nxt   = (n_opt != 3'd0) ? ST_REQOPT : ST_REQPCK;
                end
                ST_REQPCK: nxt = ST_RSPS;
                ST_RSPS: begin
                    n_x = chr_data;
                    nxt = (chr_data == 8'hFF) ? ST_RSP0 : ST_OFF;
                end
                ST_RSP0: begin
                    n_x    = rsp_xor ^ chr_data;
                    n_opt  = chr_data[6:4];
                    n_has1 = chr_data[4];
                    if ((chr_data[6:4] & ~req_mask) != 3'd0) nxt = ST_OFF;
                    else nxt = (chr_data[6:4] != 3'd0) ? ST_RSPOPT : ST_RSPPCK;
                end
                ST_RSPOPT: begin
                    n_x   = rsp_xor ^ chr_data;
                    n_opt = opt_mask & (opt_mask - 3'd1);
                    if (opt_mask[0] && (chr_data != req_pps1)) nxt = ST_OFF;
                    else nxt = (n_opt != 3'd0) ? ST_RSPOPT : ST_RSPPCK;
                end
                ST_RSPPCK: begin
                    fire = ((rsp_xor ^ chr_data) == 8'h00) && rsp_has1 && lut_ok;
                    nxt  = ST_OFF;
                end
                default: nxt = ST_OFF;
            endcase
        end
    end

    // State register and parse context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_OFF;
            ifb_mask  <= '0;
            hist_left <= '0;
            need_tck  <= 1'b0;
            req_mask  <= '0;
            opt_mask  <= '0;
            req_pps1  <= '0;
            rsp_xor   <= '0;
            rsp_has1  <= 1'b0;
        end else begin
            st        <= nxt;
            ifb_mask  <= n_ifb;
            hist_left <= n_hist;
            need_tck  <= n_tck;
            req_mask  <= n_req;
            opt_mask  <= n_opt;
            req_pps1  <= n_rp1;
            rsp_xor   <= n_x;
            rsp_has1  <= n_has1;
        end
    end

    // Outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            etu_half    <= DEF_HALF;
            etu_one     <= DEF_ONE;
            etu_onehalf <= DEF_OH;
            etu_load    <= 1'b0;
            act_flag    <= 1'b0;
        end else begin
            etu_load <= 1'b0;
            act_flag <= 1'b0;
            if (sess_rise) begin
                etu_half    <= DEF_HALF;
                etu_one     <= DEF_ONE;
                etu_onehalf <= DEF_OH;
                etu_load    <= 1'b1;
            end else if (fire) begin
                etu_half    <= lut_one >> 1;
                etu_one     <= lut_one;
                etu_onehalf <= lut_one + (lut_one >> 1);
                etu_load    <= 1'b1;
                act_flag    <= 1'b1;
            end
        end
    end

    // R2
    rise_restores_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(card_rst) |=> (etu_load && !act_flag && etu_one == DEF_ONE));

    // R8
    act_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_flag |-> etu_load);

    // R8
    etu_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (etu_half == (etu_one >> 1)) && (etu_onehalf == etu_one + etu_half));

    // R10
    counts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !etu_load |-> ($stable(etu_one) && $stable(etu_half) && $stable(etu_onehalf)));

    // R11
    low_rst_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!card_rst && chr_vld) |=> !etu_load);

endmodule

// File: tb/ppsx_tracker_tb_top.sv
module ppsx_tracker_tb_top;

    localparam int ETU_W = 12;

    typedef struct packed {
        logic [15:0]  tag;
        logic [4:0]   n;
        logic [127:0] b;
        logic         ld;
        logic [11:0]  one;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{"R8", 5'd10, {8'h3B,8'h00,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h10,8'h94,8'h7B,48'h0}, 1'b1, 12'd64},
        '{"R4", 5'd16, {8'h3B,8'h92,8'h11,8'h80,8'h01,8'h41,8'h42,8'h55,8'hFF,8'h10,8'h12,8'hFD,8'hFF,8'h10,8'h12,8'hFD}, 1'b1, 12'd186},
        '{"R3", 5'd10, {8'h3E,8'h00,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h10,8'h94,8'h7B,48'h0}, 1'b0, 12'd372},
        '{"R5", 5'd11, {8'h3B,8'h00,8'hAA,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h10,8'h94,8'h7B,40'h0}, 1'b0, 12'd372},
        '{"R6", 5'd12, {8'h3B,8'h00,8'hFF,8'h70,8'h94,8'h01,8'h02,8'h18,8'hFF,8'h10,8'h94,8'h7B,32'h0}, 1'b1, 12'd64},
        '{"R8", 5'd10, {8'h3B,8'h00,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h10,8'h94,8'h7C,48'h0}, 1'b0, 12'd372},
        '{"R7", 5'd10, {8'h3B,8'h00,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h10,8'h95,8'h7A,48'h0}, 1'b0, 12'd372},
        '{"R7", 5'd9,  {8'h3B,8'h00,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h00,8'hFF,56'h0}, 1'b0, 12'd372},
        '{"R9", 5'd10, {8'h3B,8'h00,8'hFF,8'h10,8'h71,8'h9E,8'hFF,8'h10,8'h71,8'h9E,48'h0}, 1'b0, 12'd372},
        '{"R4", 5'd13, {8'h3B,8'hE0,8'h22,8'h33,8'h00,8'hFF,8'h10,8'h94,8'h7B,8'hFF,8'h10,8'h94,8'h7B,24'h0}, 1'b1, 12'd64},
        '{"R9", 5'd10, {8'h3B,8'h00,8'hFF,8'h10,8'h90,8'h7F,8'hFF,8'h10,8'h90,8'h7F,48'h0}, 1'b0, 12'd372},
        '{"R9", 5'd10, {8'h3B,8'h00,8'hFF,8'h10,8'h01,8'hEE,8'hFF,8'h10,8'h01,8'hEE,48'h0}, 1'b1, 12'd372},
        '{"R7", 5'd9,  {8'h3B,8'h00,8'hFF,8'h00,8'hFF,8'hFF,8'h10,8'h94,8'h7B,56'h0}, 1'b0, 12'd372}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic card_rst = 1'b0;
    logic chr_vld = 1'b0;
    logic [7:0] chr_data = '0;
    logic [ETU_W-1:0] etu_half, etu_one, etu_onehalf;
    logic etu_load, act_flag;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ppsx_tracker #(.ETU_W(ETU_W), .DEF_ETU(372)) dut_i (
        .clk(clk), .rst_n(rst_n), .card_rst(card_rst),
        .chr_vld(chr_vld), .chr_data(chr_data),
        .etu_half(etu_half), .etu_one(etu_one), .etu_onehalf(etu_onehalf),
        .etu_load(etu_load), .act_flag(act_flag)
    );

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic chk_counts(input string req, input int one);
        chk(etu_one == one, req, etu_one, one);
        chk(etu_half == one / 2, req, etu_half, one / 2);
        chk(etu_onehalf == one + one / 2, req, etu_onehalf, one + one / 2);
    endtask

    // Strobe one character; outputs are compared one cycle later.
    task automatic send(input logic [7:0] c);
        @(negedge clk);
        chr_data = c;
        chr_vld  = 1'b1;
        @(negedge clk);
        chr_vld  = 1'b0;
    endtask

    task automatic open_session(input string req);
        @(negedge clk);
        card_rst = 1'b0;
        @(negedge clk);
        card_rst = 1'b1;
        @(negedge clk);
        chk(etu_load && !act_flag, req, {etu_load, act_flag}, 2);
        chk_counts(req, 372);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(!etu_load && !act_flag, "R1", {etu_load, act_flag}, 0);
        chk_counts("R1", 372);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!etu_load && !act_flag, "R1", {etu_load, act_flag}, 0);

        for (int v = 0; v < NV; v++) begin
            string tg;
            int    exp_one;
            tg = $sformatf("%s vec%0d", VECS[v].tag, v);
            open_session("R2");
            for (int i = 0; i < int'(VECS[v].n); i++) begin
                send(VECS[v].b[127 - 8 * i -: 8]);
                if (i < int'(VECS[v].n) - 1) begin
                    chk(!etu_load && !act_flag, tg, {etu_load, act_flag}, 0);
                end else begin
                    exp_one = VECS[v].ld ? int'(VECS[v].one) : 372;
                    chk(etu_load == VECS[v].ld, tg, etu_load, VECS[v].ld);
                    chk(act_flag == VECS[v].ld, tg, act_flag, VECS[v].ld);
                    chk_counts(tg, exp_one);
                end
            end
            // R10: tracker is inactive now; more PPS-looking traffic does nothing
            exp_one = VECS[v].ld ? int'(VECS[v].one) : 372;
            send(8'hFF);
            send(8'h10);
            chk(!etu_load && !act_flag, "R10", {etu_load, act_flag}, 0);
            chk_counts("R10", exp_one);
        end

        // R11: characters strobed while card_rst is low are ignored
        open_session("R2");
        send(8'h3B); send(8'h00); send(8'hFF); send(8'h10); send(8'h94);
        @(negedge clk);
        card_rst = 1'b0;
        send(8'h7B); send(8'hFF); send(8'h10); send(8'h94); send(8'h7B);
        chk(!etu_load && !act_flag, "R11", {etu_load, act_flag}, 0);
        chk_counts("R11", 372);

        // R2: a reset rise mid-session restarts parsing and restores defaults
        open_session("R2");
        send(8'h3B); send(8'h00); send(8'hFF); send(8'h10); send(8'h94); send(8'h7B);
        send(8'hFF); send(8'h10); send(8'h94); send(8'h7B);
        chk(etu_load && act_flag, "R8", {etu_load, act_flag}, 3);
        chk_counts("R8", 64);
        send(8'h3B); send(8'h00); send(8'hFF);
        open_session("R2");
        send(8'h3B); send(8'h00); send(8'hFF); send(8'h10); send(8'h12); send(8'hFD);
        send(8'hFF); send(8'h10); send(8'h12); send(8'hFD);
        chk(etu_load && act_flag, "R2", {etu_load, act_flag}, 3);
        chk_counts("R2", 186);
        @(negedge clk);
        chk(!etu_load && !act_flag, "R8", {etu_load, act_flag}, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule